// File: doc/BRIEF.md
# Embedded Video Timing Code Inserter

This block merges line and frame timing into a byte-pair video stream, so that no separate sync wires have to travel with it. On every clock it puts out one chroma/luma pair. That pair is one of three things: a clipped video sample, an idle filler, or a two-value event word. An event word holds a chroma phase code (the top two code values) followed by a luma value that names the event. The events are start of active video, end of active video, a line reference (its value tells an active line from a blanked one), and a field reference (its value tells an odd field from an even one).

The controller is a three-state machine.
- `ST_BLANK` means no video is flowing. When the qualified active window rises, the machine moves to `ST_ACTIVE` and emits the start marker.
- `ST_ACTIVE` emits the sample captured on the previous cycle. When the window falls, the machine moves to `ST_TAIL`, and that cycle's pair is the last sample.
- `ST_TAIL` emits the end marker and always returns to `ST_BLANK`.

Line and field references are recorded by edge trackers. A reference that arrives while a line is in flight is held, and it is emitted in the first free `ST_BLANK` slot. Line references take precedence over field references. The active window needs at least two low cycles between lines.

Top module: `vtc_inserter`

## Requirements
- R1: After reset the output carries the idle pair (chroma 0x80, luma 0x10) with `evt_flag` low.
- R2: On the first cycle of the active window on an active line, the next pair is the start event: `evt_flag` high, chroma 0xFE, luma 0x20.
- R3: Each sample presented while the window is high appears clipped one cycle later with `evt_flag` low. The sample of the last high cycle is output on the cycle after the window falls.
- R4: The pair after the last sample is the end event (luma 0x30). Its chroma is 0xFE when the line carried an even number of samples and 0xFF when it carried an odd number. Later events in the blanking interval reuse that chroma phase.
- R5: On a blanked line (`line_is_active` low) the active window is ignored: only idle pairs or reference events are output.
- R6: A rising edge of `line_ref` seen in a free blanking slot emits the line event in the same cycle. Its luma is 0x40 if `line_is_active` was high at that edge and 0x50 otherwise.
- R7: A rising edge of `line_ref` during an active line is held, and its event follows directly after the end event.
- R8: A falling edge of `frame_ref` emits the field event: luma 0x60 when `line_ref` was low at that edge (odd field) and 0x70 when it was high (even field).
- R9: When a line event and a field event are due in the same slot, the line event goes first and the field event takes the next slot.
- R10: Video samples are clamped into 2..253 so that 0, 1, 254 and 255 appear only in event words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_win | input | 1 | Video-active window qualifier |
| line_ref | input | 1 | Line reference; rising edge starts a line |
| frame_ref | input | 1 | Field reference; falling edge marks a field |
| line_is_active | input | 1 | 1 = active line, 0 = blanked line |
| pix_y | input | 8 | Luma sample |
| pix_c | input | 8 | Multiplexed chroma sample |
| out_c | output | 8 | Chroma or phase code |
| out_y | output | 8 | Luma or event code |
| evt_flag | output | 1 | High when the pair is an event word |

## Verification
The hardest situation to reach is several timing events piling up while a line is still being sent. That happens when a line edge and a field edge land in the same cycle in the middle of a short active line. The stimulus raises `line_ref` and drops `frame_ref` on the same clock inside a two-sample line. Then it checks the exact order: last sample, end marker, line event, field event. A full sweep of all 256 luma and chroma values through one long line exercises the clamp at both ends.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
    typedef enum logic [1:0] {
        ST_BLANK  = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_TAIL   = 2'd2
    } vtc_state_t;

    localparam int EV_N    = 6;
    localparam int EV_SAV  = 0;
    localparam int EV_EAV  = 1;
    localparam int EV_HACT = 2;
    localparam int EV_HBLK = 3;
    localparam int EV_VODD = 4;
    localparam int EV_VEVN = 5;
endpackage

// File: rtl/vtc_clip.sv
module vtc_clip #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam logic [DW-1:0] LO = DW'(2);
    localparam logic [DW-1:0] HI = DW'((2 ** DW) - 3);

    always_comb begin
        if (din < LO)
            dout = LO;
        else if (din > HI)
            dout = HI;
        else
            dout = din;
    end
endmodule

// File: rtl/vtc_ref_track.sv
module vtc_ref_track #(
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    input  logic attr,
    input  logic take,
    output logic hit,
    output logic hit_attr
);
    logic sig_q;
    logic pend_q;
    logic attr_q;
    logic edge_now;

    generate
        if (FALLING) begin : g_fall
            assign edge_now = sig_q & ~sig;
        end else begin : g_rise
            assign edge_now = ~sig_q & sig;
        end
    endgenerate

    assign hit      = pend_q | edge_now;
    assign hit_attr = edge_now ? attr : attr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_q  <= 1'b0;
            pend_q <= 1'b0;
            attr_q <= 1'b0;
        end else begin
            sig_q <= sig;
            if (edge_now) begin
                attr_q <= attr;
                pend_q <= ~take;
            end else if (take) begin
                pend_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vtc_code_mux.sv
module vtc_code_mux #(
    parameter int DW = 8,
    parameter int N  = 6,
    parameter logic [N*DW-1:0] CODES = '0
) (
    input  logic [N-1:0]  sel,
    output logic [DW-1:0] code
);
    logic [DW-1:0] terms [N];

    generate
        for (genvar i = 0; i < N; i++) begin : g_term
            assign terms[i] = sel[i] ? CODES[i*DW +: DW] : '0;
        end
    endgenerate

    always_comb begin
        code = '0;
        for (int i = 0; i < N; i++)
            code = code | terms[i];
    end
endmodule

// File: rtl/vtc_inserter.sv
module vtc_inserter
    import vtc_pkg::*;
#(
    parameter int DW = 8,
    parameter logic [EV_N*DW-1:0] EVENT_CODES =
        {8'h70, 8'h60, 8'h50, 8'h40, 8'h30, 8'h20}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_win,
    input  logic          line_ref,
    input  logic          frame_ref,
    input  logic          line_is_active,
    input  logic [DW-1:0] pix_y,
    input  logic [DW-1:0] pix_c,
    output logic [DW-1:0] out_c,
    output logic [DW-1:0] out_y,
    output logic          evt_flag
);
    localparam logic [DW-1:0] CB_CODE  = DW'((2 ** DW) - 2);
    localparam logic [DW-1:0] CR_CODE  = DW'((2 ** DW) - 1);
    localparam logic [DW-1:0] IDLE_C   = DW'(2 ** (DW - 1));
    localparam logic [DW-1:0] IDLE_Y   = DW'(2 ** (DW - 4));
    localparam logic [DW-1:0] SAV_CODE = EVENT_CODES[EV_SAV*DW +: DW];
    localparam logic [DW-1:0] EAV_CODE = EVENT_CODES[EV_EAV*DW +: DW];
    localparam logic [DW-1:0] HA_CODE  = EVENT_CODES[EV_HACT*DW +: DW];
    localparam logic [DW-1:0] HB_CODE  = EVENT_CODES[EV_HBLK*DW +: DW];

    vtc_state_t st, st_nx;
    logic          vact_eff;
    logic          slot_free;
    logic          h_hit, h_attr, v_hit, v_attr;
    logic          take_h, take_v;
    logic [EV_N-1:0] sel;
    logic [DW-1:0] ev_code;
    logic [DW-1:0] cy, cc;
    logic [DW-1:0] d_y, d_c;
    logic          phase_cr;

    assign vact_eff  = act_win & line_is_active;
    assign slot_free = (st == ST_BLANK) && !vact_eff;
    assign take_h    = slot_free && h_hit;
    assign take_v    = slot_free && v_hit && !h_hit;

    vtc_clip #(.DW(DW)) u_clip_y (.din(pix_y), .dout(cy));
    vtc_clip #(.DW(DW)) u_clip_c (.din(pix_c), .dout(cc));

    vtc_ref_track #(.FALLING(1'b0)) u_href (
        .clk(clk), .rst_n(rst_n), .sig(line_ref), .attr(line_is_active),
        .take(take_h), .hit(h_hit), .hit_attr(h_attr)
    );

    vtc_ref_track #(.FALLING(1'b1)) u_vref (
        .clk(clk), .rst_n(rst_n), .sig(frame_ref), .attr(line_ref),
        .take(take_v), .hit(v_hit), .hit_attr(v_attr)
    );

    always_comb begin
        sel          = '0;
        sel[EV_SAV]  = (st == ST_BLANK) && vact_eff;
        sel[EV_EAV]  = (st == ST_TAIL);
        sel[EV_HACT] = take_h && h_attr;
        sel[EV_HBLK] = take_h && !h_attr;
        sel[EV_VODD] = take_v && !v_attr;
        sel[EV_VEVN] = take_v && v_attr;
    end

    vtc_code_mux #(.DW(DW), .N(EV_N), .CODES(EVENT_CODES)) u_mux (
        .sel(sel), .code(ev_code)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_BLANK:  if (vact_eff) st_nx = ST_ACTIVE;
            ST_ACTIVE: if (!vact_eff) st_nx = ST_TAIL;
            ST_TAIL:   st_nx = ST_BLANK;
            default:   st_nx = ST_BLANK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_BLANK;
        else
            st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_c    <= IDLE_C;
            out_y    <= IDLE_Y;
            evt_flag <= 1'b0;
            d_y      <= IDLE_Y;
            d_c      <= IDLE_C;
            phase_cr <= 1'b0;
        end else begin
            d_y <= cy;
            d_c <= cc;
            if (|sel) begin
                evt_flag <= 1'b1;
                out_y    <= ev_code;
                out_c    <= (sel[EV_SAV] || !phase_cr) ? CB_CODE : CR_CODE;
                if (sel[EV_SAV])
                    phase_cr <= 1'b0;
            end else if (st == ST_ACTIVE) begin
                evt_flag <= 1'b0;
                out_y    <= d_y;
                out_c    <= d_c;
                phase_cr <= ~phase_cr;
            end else begin
                evt_flag <= 1'b0;
                out_y    <= IDLE_Y;
                out_c    <= IDLE_C;
            end
        end
    end

    AST_SAV_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACTIVE && $past(st) == ST_BLANK) |-> (evt_flag && out_y == SAV_CODE && out_c == CB_CODE)); // R2
    AST_EAV_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BLANK && $past(st) == ST_TAIL) |-> (evt_flag && out_y == EAV_CODE)); // R4
    AST_PHASE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_flag |-> (out_c == CB_CODE || out_c == CR_CODE)); // R4
    AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BLANK && !line_is_active) |=> (st == ST_BLANK)); // R5
    AST_HREF_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag && (out_y == HA_CODE || out_y == HB_CODE)) |-> ($past(st) == ST_BLANK)); // R7
    AST_DATA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_flag |-> (out_y >= DW'(2) && out_y <= DW'((2 ** DW) - 3) &&
                       out_c >= DW'(2) && out_c <= DW'((2 ** DW) - 3))); // R10
endmodule

// File: tb/tb_vtc_inserter.sv
module tb_vtc_inserter;
    logic clk = 1'b0;
    logic rst_n;
    logic act_win, line_ref, frame_ref, line_is_active;
    logic [7:0] pix_y, pix_c;
    logic [7:0] out_c, out_y;
    logic evt_flag;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    vtc_inserter dut (
        .clk(clk), .rst_n(rst_n), .act_win(act_win), .line_ref(line_ref),
        .frame_ref(frame_ref), .line_is_active(line_is_active),
        .pix_y(pix_y), .pix_c(pix_c),
        .out_c(out_c), .out_y(out_y), .evt_flag(evt_flag)
    );

    function automatic logic [7:0] clipf(input int v);
        if (v < 2) return 8'd2;
        if (v > 253) return 8'd253;
        return 8'(v);
    endfunction

    task automatic tick(input logic a, input logic h, input logic v, input logic la,
                        input logic [7:0] y, input logic [7:0] c);
        @(negedge clk);
        act_win = a; line_ref = h; frame_ref = v; line_is_active = la;
        pix_y = y; pix_c = c;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic ef, input logic [7:0] ec,
                       input logic [7:0] ey);
        checks++;
        if (evt_flag !== ef || out_c !== ec || out_y !== ey) begin
            fails++;
            $display("FAIL %s: got flag=%0b c=%02h y=%02h, expected flag=%0b c=%02h y=%02h",
                     req, evt_flag, out_c, out_y, ef, ec, ey);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        act_win = 0; line_ref = 0; frame_ref = 0; line_is_active = 0;
        pix_y = 0; pix_c = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset idle", 1'b0, 8'h80, 8'h10);

        // R2/R3/R10: full sweep of sample values through one long line
        for (int i = 0; i < 256; i++) begin
            tick(1, 0, 0, 1, 8'(i), 8'(255 - i));
            if (i == 0)
                chk("R2 start event", 1'b1, 8'hFE, 8'h20);
            else
                chk("R3 R10 clipped data", 1'b0, clipf(255 - (i - 1)), clipf(i - 1));
        end
        tick(0, 0, 0, 1, 0, 0);
        chk("R3 last sample after fall", 1'b0, 8'd2, 8'd253);
        tick(0, 0, 0, 1, 0, 0);
        chk("R4 end event even count", 1'b1, 8'hFE, 8'h30);
        tick(0, 0, 0, 1, 0, 0);
        chk("R1 idle after end", 1'b0, 8'h80, 8'h10);

        // R5: blanked line ignores the window
        for (int k = 0; k < 4; k++) begin
            tick(1, 0, 0, 0, 8'd100, 8'd100);
            chk("R5 blanked line idle", 1'b0, 8'h80, 8'h10);
        end
        tick(0, 0, 0, 0, 0, 0);
        chk("R5 blanked line idle after", 1'b0, 8'h80, 8'h10);

        // R6: line event on a blanked line, free slot
        tick(0, 1, 0, 0, 0, 0);
        chk("R6 line event blanked", 1'b1, 8'hFE, 8'h50);
        tick(0, 0, 0, 0, 0, 0);
        chk("R6 idle after", 1'b0, 8'h80, 8'h10);

        // R7/R4: three-sample line, line edge arrives mid-line
        tick(1, 0, 0, 1, 8'd100, 8'd50);
        chk("R2 start event short", 1'b1, 8'hFE, 8'h20);
        tick(1, 1, 0, 1, 8'd101, 8'd51);
        chk("R7 data not displaced", 1'b0, 8'd50, 8'd100);
        tick(1, 1, 0, 1, 8'd102, 8'd52);
        chk("R7 data not displaced", 1'b0, 8'd51, 8'd101);
        tick(0, 1, 0, 1, 0, 0);
        chk("R3 last short sample", 1'b0, 8'd52, 8'd102);
        tick(0, 1, 0, 1, 0, 0);
        chk("R4 end event odd count", 1'b1, 8'hFF, 8'h30);
        tick(0, 1, 0, 1, 0, 0);
        chk("R7 deferred line event", 1'b1, 8'hFF, 8'h40);
        tick(0, 0, 0, 1, 0, 0);
        chk("R7 idle after", 1'b0, 8'h80, 8'h10);

        // R8: odd field
        tick(0, 0, 1, 0, 0, 0);
        chk("R8 no event on rising frame_ref", 1'b0, 8'h80, 8'h10);
        tick(0, 0, 0, 0, 0, 0);
        chk("R8 odd field", 1'b1, 8'hFF, 8'h60);

        // R8: even field
        tick(0, 1, 1, 0, 0, 0);
        chk("R6 line event before field", 1'b1, 8'hFF, 8'h50);
        tick(0, 1, 0, 0, 0, 0);
        chk("R8 even field", 1'b1, 8'hFF, 8'h70);
        tick(0, 0, 0, 0, 0, 0);
        chk("R8 idle after", 1'b0, 8'h80, 8'h10);

        // R9: simultaneous edges in a free slot
        tick(0, 0, 1, 0, 0, 0);
        chk("R9 setup idle", 1'b0, 8'h80, 8'h10);
        tick(0, 1, 0, 0, 0, 0);
        chk("R9 line event first", 1'b1, 8'hFF, 8'h50);
        tick(0, 1, 0, 0, 0, 0);
        chk("R9 field event second", 1'b1, 8'hFF, 8'h70);
        tick(0, 0, 0, 0, 0, 0);
        chk("R9 idle after", 1'b0, 8'h80, 8'h10);

        // R9/R7: both edges pile up inside a two-sample line
        tick(0, 0, 1, 1, 0, 0);
        chk("R9 setup idle", 1'b0, 8'h80, 8'h10);
        tick(1, 0, 1, 1, 8'd0, 8'd255);
        chk("R2 start event two-sample", 1'b1, 8'hFE, 8'h20);
        tick(1, 1, 0, 1, 8'd1, 8'd254);
        chk("R10 low clamp", 1'b0, 8'd253, 8'd2);
        tick(0, 1, 0, 1, 0, 0);
        chk("R10 low clamp second", 1'b0, 8'd253, 8'd2);
        tick(0, 1, 0, 1, 0, 0);
        chk("R4 end event two-sample", 1'b1, 8'hFE, 8'h30);
        tick(0, 1, 0, 1, 0, 0);
        chk("R9 deferred line first", 1'b1, 8'hFE, 8'h40);
        tick(0, 1, 0, 1, 0, 0);
        chk("R9 deferred field second", 1'b1, 8'hFE, 8'h70);
        tick(0, 0, 0, 1, 0, 0);
        chk("R9 idle after pile-up", 1'b0, 8'h80, 8'h10);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule